// File: doc/BRIEF.md
# Code Memory Lock and Scrambled Read-Back Guard

This block sits beside the on-chip code memory of a small microcontroller and decides what the outside world may do with that memory. It decodes the programming-mode pin levels into one operating mode. It holds a two-bit lock state and a 32-byte scramble table, and it forms the byte that is presented during a read-back. The raw code byte comes from the memory itself, which is outside this block; the block only scrambles it, blocks it or passes it through.

The outputs tell the rest of the chip three things: whether a code-programming pulse may reach the memory array, whether code running from external memory may read internal code bytes, and which external-access level the core should use. Once the part is locked, the external-access level is frozen at the value that was present while the reset pin was last held high. Two fixed identification bytes can always be read back, whatever the lock state. A single-cycle erase request returns the lock state and the scramble table to the blank condition.

Top module: `code_lock_guard`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `vfy_oe` is 0, `vfy_data` is FFh, no lock is set, `intcode_rd_ok` is 1 and every scramble byte is FFh.
- R2: When `ctl_reset`=1 and `ctl_store_n`=0, the mode is taken from {`ctl_pulse_n`,`ctl_hv`,`ctl_sel_a`,`ctl_sel_b`,`ctl_sel_c`,`ctl_sel_d`}. The codes are: 010111 program code, 010101 program scramble byte, 011111 set lock bit 1, 011100 set lock bit 2, 100011 read-back, 100000 identification read. Every other combination is idle.
- R3: In read-back mode, `vfy_data` one clock after the inputs is the bitwise XNOR of `code_in` with the scramble byte selected by `addr[4:0]`, and `vfy_oe` is 1.
- R4: While the scramble table is blank (all FFh), a read-back returns `code_in` unchanged.
- R5: A program-scramble cycle writes only when `addr` bits above bit 4 are all zero. The write can only clear bits: the new byte is the old byte AND `code_in`. Out-of-range addresses leave the table unchanged.
- R6: `prog_en` is 1 only in program-code mode with no lock bit set.
- R7: With lock bit 1 set, `prog_en` stays 0, scramble writes are ignored and `intcode_rd_ok` is 0. `ext_access_eff` holds the `ext_access_in` level sampled at the last edge with `ctl_reset`=1. Read-back still works.
- R8: With both lock bits set, a read-back gives `vfy_oe`=0 and `vfy_data`=FFh.
- R9: The reserved state with only lock bit 2 set applies the same restrictions as lock bit 1 alone.
- R10: An identification read returns 89h at address 030h and `SIG_DEV` (default 51h) at 031h, and FFh at any other address, with `vfy_oe`=1, regardless of the lock state.
- R11: `erase_all` high at a clock edge clears both lock bits and sets every scramble byte to FFh.
- R12: In any mode other than read-back and identification read, the next cycle shows `vfy_oe`=0 and `vfy_data`=FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_reset | input | 1 | Device reset pin level |
| ctl_store_n | input | 1 | Program-store strobe pin level |
| ctl_pulse_n | input | 1 | Programming pulse pin, low while pulsing |
| ctl_hv | input | 1 | High programming voltage present on access pin |
| ctl_sel_a | input | 1 | Mode select pin A |
| ctl_sel_b | input | 1 | Mode select pin B |
| ctl_sel_c | input | 1 | Mode select pin C |
| ctl_sel_d | input | 1 | Mode select pin D |
| erase_all | input | 1 | Full erase request |
| ext_access_in | input | 1 | Live external-access level |
| addr | input | ADDR_W | Code address |
| code_in | input | 8 | Raw byte read from the code memory, or the programming data |
| vfy_data | output | 8 | Read-back data, registered |
| vfy_oe | output | 1 | Read-back output enable, registered |
| prog_en | output | 1 | Code programming pulse may reach the memory |
| intcode_rd_ok | output | 1 | External code may read internal code bytes |
| ext_access_eff | output | 1 | External-access level the core should use |

## Verification
The assertions take for granted that the mode pins and the address stay stable across each clock edge and that a programming pulse covers at least one edge. They also assume that the erase request is a clean synchronous level. The stimulus changes every input only on the falling clock edge and holds each programming mode for exactly one rising edge. It returns the pins to an idle code between operations, so no mode is ever decoded from a half-changed pin set.

// File: rtl/clg_pkg.sv
// Shared types and helpers for the code lock guard.
// Assumes an 8-bit code byte and a blank (erased) byte value of all ones.
package clg_pkg;

    typedef enum logic [2:0] {
        MD_IDLE,
        MD_PROG_CODE,
        MD_PROG_SCR,
        MD_SET_LK1,
        MD_SET_LK2,
        MD_READBACK,
        MD_IDENT
    } clg_mode_t;

    localparam logic [7:0] BYTE_BLANK = 8'hFF;

    // Pin codes {pulse_n, hv, sel_a, sel_b, sel_c, sel_d}
    localparam logic [5:0] PAT_PROG_CODE = 6'b010111;
    localparam logic [5:0] PAT_PROG_SCR  = 6'b010101;
    localparam logic [5:0] PAT_SET_LK1   = 6'b011111;
    localparam logic [5:0] PAT_SET_LK2   = 6'b011100;
    localparam logic [5:0] PAT_READBACK  = 6'b100011;
    localparam logic [5:0] PAT_IDENT     = 6'b100000;

    // Scramble function: bitwise XNOR of code and key
    function automatic logic [7:0] scramble(input logic [7:0] code, input logic [7:0] key);
        return ~(code ^ key);
    endfunction

endpackage

// File: rtl/clg_mode_dec.sv
// Mode decoder: turns the programming-mode pin levels into one mode.
// Assumes the pins are static across the sampling clock edge.
module clg_mode_dec
    import clg_pkg::*;
(
    input  logic      ctl_reset,
    input  logic      ctl_store_n,
    input  logic      ctl_pulse_n,
    input  logic      ctl_hv,
    input  logic      ctl_sel_a,
    input  logic      ctl_sel_b,
    input  logic      ctl_sel_c,
    input  logic      ctl_sel_d,
    output clg_mode_t mode
);

    logic [5:0] pat;
    logic       armed;

    assign pat   = {ctl_pulse_n, ctl_hv, ctl_sel_a, ctl_sel_b, ctl_sel_c, ctl_sel_d};
    assign armed = ctl_reset && !ctl_store_n;

    // Match the pin pattern against the mode table
    always_comb begin
        mode = MD_IDLE;
        if (armed) begin
            case (pat)
                PAT_PROG_CODE: mode = MD_PROG_CODE;
                PAT_PROG_SCR:  mode = MD_PROG_SCR;
                PAT_SET_LK1:   mode = MD_SET_LK1;
                PAT_SET_LK2:   mode = MD_SET_LK2;
                PAT_READBACK:  mode = MD_READBACK;
                PAT_IDENT:     mode = MD_IDENT;
                default:       mode = MD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/clg_lock_store.sv
// Lock and scramble state: two lock bits, the scramble table and the
// frozen external-access level. Reset models a blank part.
// Assumes erase and writes are single-edge synchronous events.
module clg_lock_store
    import clg_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int SCR_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  clg_mode_t         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code_in,
    input  logic              erase_all,
    input  logic              ctl_reset,
    input  logic              ext_access_in,
    output logic [1:0]        lock_q,
    output logic [7:0]        scr_rd,
    output logic              ext_access_eff
);

    localparam int SEL_W = $clog2(SCR_DEPTH);

    logic [7:0]       scr_mem [SCR_DEPTH];
    logic [SEL_W-1:0] sel;
    logic             in_range;
    logic             lock_any;
    logic             scr_we;
    logic             ea_hold;

    assign sel      = addr[SEL_W-1:0];
    assign in_range = (addr[ADDR_W-1:SEL_W] == '0);
    assign lock_any = |lock_q;
    assign scr_we   = (mode == MD_PROG_SCR) && !lock_any && in_range;

    // One storage byte per table entry; programming can only clear bits
    for (genvar g = 0; g < SCR_DEPTH; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n || erase_all)
                scr_mem[g] <= BYTE_BLANK;
            else if (scr_we && sel == SEL_W'(g))
                scr_mem[g] <= scr_mem[g] & code_in;
        end
    end

    // Lock bits: set by their programming modes, cleared only by erase
    always_ff @(posedge clk) begin
        if (!rst_n || erase_all)
            lock_q <= 2'b00;
        else if (mode == MD_SET_LK1)
            lock_q[0] <= 1'b1;
        else if (mode == MD_SET_LK2)
            lock_q[1] <= 1'b1;
    end

    // Track the external-access level while the reset pin is high
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_reset)
            ea_hold <= ext_access_in;
    end

    assign scr_rd         = scr_mem[sel];
    assign ext_access_eff = lock_any ? ea_hold : ext_access_in;

endmodule

// File: rtl/clg_verify_path.sv
// Read-back path: scrambles, blocks or substitutes the outgoing byte and
// registers it with its output enable.
// Assumes scr_rd already reflects the current address.
module clg_verify_path
    import clg_pkg::*;
#(
    parameter int         ADDR_W  = 13,
    parameter logic [7:0] SIG_MFR = 8'h89,
    parameter logic [7:0] SIG_DEV = 8'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  clg_mode_t         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code_in,
    input  logic [7:0]        scr_rd,
    input  logic [1:0]        lock_q,
    output logic [7:0]        vfy_data,
    output logic              vfy_oe
);

    localparam logic [ADDR_W-1:0] LOC_MFR = ADDR_W'(12'h030);
    localparam logic [ADDR_W-1:0] LOC_DEV = ADDR_W'(12'h031);

    logic [7:0] nxt_data;
    logic       nxt_oe;
    logic       rd_blocked;

    assign rd_blocked = &lock_q;

    // Choose the next outgoing byte for the current mode
    always_comb begin
        nxt_data = BYTE_BLANK;
        nxt_oe   = 1'b0;
        if (mode == MD_READBACK && !rd_blocked) begin
            nxt_data = scramble(code_in, scr_rd);
            nxt_oe   = 1'b1;
        end else if (mode == MD_IDENT) begin
            nxt_oe = 1'b1;
            if (addr == LOC_MFR)
                nxt_data = SIG_MFR;
            else if (addr == LOC_DEV)
                nxt_data = SIG_DEV;
        end
    end

    // Register the outgoing byte and enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vfy_data <= BYTE_BLANK;
            vfy_oe   <= 1'b0;
        end else begin
            vfy_data <= nxt_data;
            vfy_oe   <= nxt_oe;
        end
    end

endmodule

// File: rtl/code_lock_guard.sv
// Code memory lock and scrambled read-back guard, top level.
// Wires the mode decoder, lock store and read-back path and forms the
// programming and internal-read permits. The code memory is external.
module code_lock_guard
    import clg_pkg::*;
#(
    parameter int         ADDR_W    = 13,
    parameter int         SCR_DEPTH = 32,
    parameter logic [7:0] SIG_MFR   = 8'h89,
    parameter logic [7:0] SIG_DEV   = 8'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_reset,
    input  logic              ctl_store_n,
    input  logic              ctl_pulse_n,
    input  logic              ctl_hv,
    input  logic              ctl_sel_a,
    input  logic              ctl_sel_b,
    input  logic              ctl_sel_c,
    input  logic              ctl_sel_d,
    input  logic              erase_all,
    input  logic              ext_access_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code_in,
    output logic [7:0]        vfy_data,
    output logic              vfy_oe,
    output logic              prog_en,
    output logic              intcode_rd_ok,
    output logic              ext_access_eff
);

    clg_mode_t  mode_w;
    logic [1:0] lock_w;
    logic [7:0] scr_w;

    clg_mode_dec u_dec (
        .ctl_reset   (ctl_reset),
        .ctl_store_n (ctl_store_n),
        .ctl_pulse_n (ctl_pulse_n),
        .ctl_hv      (ctl_hv),
        .ctl_sel_a   (ctl_sel_a),
        .ctl_sel_b   (ctl_sel_b),
        .ctl_sel_c   (ctl_sel_c),
        .ctl_sel_d   (ctl_sel_d),
        .mode        (mode_w)
    );

    clg_lock_store #(.ADDR_W(ADDR_W), .SCR_DEPTH(SCR_DEPTH)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode           (mode_w),
        .addr           (addr),
        .code_in        (code_in),
        .erase_all      (erase_all),
        .ctl_reset      (ctl_reset),
        .ext_access_in  (ext_access_in),
        .lock_q         (lock_w),
        .scr_rd         (scr_w),
        .ext_access_eff (ext_access_eff)
    );

    clg_verify_path #(.ADDR_W(ADDR_W), .SIG_MFR(SIG_MFR), .SIG_DEV(SIG_DEV)) u_vfy (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_w),
        .addr     (addr),
        .code_in  (code_in),
        .scr_rd   (scr_w),
        .lock_q   (lock_w),
        .vfy_data (vfy_data),
        .vfy_oe   (vfy_oe)
    );

    // Any lock bit (including the reserved single bit 2) restricts access
    assign prog_en       = (mode_w == MD_PROG_CODE) && (lock_w == 2'b00);
    assign intcode_rd_ok = (lock_w == 2'b00);

endmodule

// File: rtl/clg_checker.sv
// Property checker for the code lock guard, bound into the top level.
// Assumes inputs change only away from the rising clock edge.
module clg_checker
    import clg_pkg::*;
#(
    parameter int         ADDR_W  = 13,
    parameter logic [7:0] SIG_MFR = 8'h89
) (
    input logic              clk,
    input logic              rst_n,
    input clg_mode_t         mode,
    input logic [1:0]        lock_q,
    input logic              erase_all,
    input logic              ctl_reset,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        vfy_data,
    input logic              vfy_oe,
    input logic              prog_en,
    input logic              ext_access_eff
);

    p_blocked_rb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_READBACK && lock_q == 2'b11) |=> (!vfy_oe && vfy_data == 8'hFF));

    p_no_prog_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != 2'b00) |-> !prog_en);

    p_lock_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q[0] && !erase_all) |=> lock_q[0]);

    p_ea_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_q != 2'b00) && !ctl_reset && !erase_all) |=> $stable(ext_access_eff));

    p_erase_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> (lock_q == 2'b00));

    p_ident_mfr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_IDENT && addr == ADDR_W'(12'h030)) |=> (vfy_oe && vfy_data == SIG_MFR));

    p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode == MD_READBACK || mode == MD_IDENT) |=> (!vfy_oe && vfy_data == 8'hFF));

endmodule

bind code_lock_guard clg_checker #(.ADDR_W(ADDR_W), .SIG_MFR(SIG_MFR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode           (mode_w),
    .lock_q         (lock_w),
    .erase_all      (erase_all),
    .ctl_reset      (ctl_reset),
    .addr           (addr),
    .vfy_data       (vfy_data),
    .vfy_oe         (vfy_oe),
    .prog_en        (prog_en),
    .ext_access_eff (ext_access_eff)
);

// File: tb/tb_code_lock_guard.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read-back results, a
// monitor pops and compares them in the cycle the registered output shows.
module tb_code_lock_guard;

    localparam int AW = 13;

    typedef struct {
        logic [7:0] d;
        logic       oe;
        int         due;
        string      req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_reset = 1'b0, ctl_store_n = 1'b1, ctl_pulse_n = 1'b1, ctl_hv = 1'b0;
    logic          ctl_sel_a = 1'b0, ctl_sel_b = 1'b0, ctl_sel_c = 1'b0, ctl_sel_d = 1'b0;
    logic          erase_all = 1'b0, ext_access_in = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    code_in = '0;
    logic [7:0]    vfy_data;
    logic          vfy_oe, prog_en, intcode_rd_ok, ext_access_eff;

    int   n_run = 0, n_fail = 0, cyc = 0;
    bit   done = 1'b0;
    bit   locked = 1'b0;
    exp_t sb[$];
    logic [7:0] model_scr [32];

    code_lock_guard dut (
        .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .ctl_store_n(ctl_store_n),
        .ctl_pulse_n(ctl_pulse_n), .ctl_hv(ctl_hv), .ctl_sel_a(ctl_sel_a),
        .ctl_sel_b(ctl_sel_b), .ctl_sel_c(ctl_sel_c), .ctl_sel_d(ctl_sel_d),
        .erase_all(erase_all), .ext_access_in(ext_access_in), .addr(addr),
        .code_in(code_in), .vfy_data(vfy_data), .vfy_oe(vfy_oe), .prog_en(prog_en),
        .intcode_rd_ok(intcode_rd_ok), .ext_access_eff(ext_access_eff)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] code_of(input logic [AW-1:0] a);
        return {a[2:0], a[7:3]} ^ a[12:5];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a mode code (armed) or idle pins
    task automatic pins(input logic [5:0] pat, input bit armed);
        ctl_reset   = armed;
        ctl_store_n = !armed;
        {ctl_pulse_n, ctl_hv, ctl_sel_a, ctl_sel_b, ctl_sel_c, ctl_sel_d} = armed ? pat : 6'b100000;
    endtask

    // Queue one read-back or identification read
    task automatic rd(input logic [5:0] pat, input logic [AW-1:0] a,
                      input logic [7:0] ed, input logic eoe, input string req);
        exp_t e;
        @(negedge clk);
        pins(pat, 1'b1);
        addr = a;
        code_in = code_of(a);
        e.d = ed; e.oe = eoe; e.due = cyc + 1; e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle_cycle(input string req);
        exp_t e;
        @(negedge clk);
        pins(6'b0, 1'b0);
        e.d = 8'hFF; e.oe = 1'b0; e.due = cyc + 1; e.req = req;
        sb.push_back(e);
    endtask

    // One-edge programming operation, then back to idle
    task automatic prog(input logic [5:0] pat, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        pins(pat, 1'b1);
        addr = a;
        code_in = d;
        if (pat == clg_pkg::PAT_PROG_SCR && !locked && a[AW-1:5] == '0)
            model_scr[a[4:0]] = model_scr[a[4:0]] & d;
        @(negedge clk);
        pins(6'b0, 1'b0);
    endtask

    task automatic do_erase();
        @(negedge clk);
        erase_all = 1'b1;
        @(negedge clk);
        erase_all = 1'b0;
        locked = 1'b0;
        for (int i = 0; i < 32; i++) model_scr[i] = 8'hFF;
    endtask

    task automatic rb(input logic [AW-1:0] a, input string req);
        rd(clg_pkg::PAT_READBACK, a, ~(code_of(a) ^ model_scr[a[4:0]]), 1'b1, req);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare each expected item in its due cycle
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk(vfy_data === e.d && vfy_oe === e.oe, e.req, {vfy_oe, vfy_data}, {e.oe, e.d});
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model_scr[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(vfy_oe === 1'b0 && vfy_data === 8'hFF, "R1 reset output", {vfy_oe, vfy_data}, 9'h0FF);
        chk(intcode_rd_ok === 1'b1, "R1 reset unlocked", {8'h0, intcode_rd_ok}, 9'h1);
        chk(prog_en === 1'b0, "R6 idle prog_en", {8'h0, prog_en}, 9'h0);

        // R4: blank table passes code through
        rb(13'h0000, "R4 blank pass");
        rb(13'h0155, "R4 blank pass");
        rb(13'h1FFF, "R4 blank pass");
        idle_cycle("R12 idle quiet");
        drain();

        // R2/R6: program-code mode permit
        @(negedge clk); pins(clg_pkg::PAT_PROG_CODE, 1'b1); #1;
        chk(prog_en === 1'b1, "R6 prog code permit", {8'h0, prog_en}, 9'h1);
        @(negedge clk); pins(clg_pkg::PAT_PROG_SCR, 1'b1); addr = 13'h1F00; #1;
        chk(prog_en === 1'b0, "R2 scramble mode no code permit", {8'h0, prog_en}, 9'h0);
        @(negedge clk); pins(6'b0, 1'b0);

        // R5: scramble programming, range and bit-clearing
        prog(clg_pkg::PAT_PROG_SCR, 13'h0003, 8'hA5);
        prog(clg_pkg::PAT_PROG_SCR, 13'h001F, 8'h0F);
        prog(clg_pkg::PAT_PROG_SCR, 13'h0023, 8'h00);
        prog(clg_pkg::PAT_PROG_SCR, 13'h0003, 8'h3C);
        // R3: XNOR read-back by low address bits
        rb(13'h0003, "R3 xnor and R5 and-write");
        rb(13'h0023, "R5 out-of-range ignored R3 index");
        rb(13'h001F, "R3 xnor last entry");
        rb(13'h1FE3, "R3 index by low bits");
        // R10: identification
        rd(clg_pkg::PAT_IDENT, 13'h0030, 8'h89, 1'b1, "R10 ident mfr");
        rd(clg_pkg::PAT_IDENT, 13'h0031, 8'h51, 1'b1, "R10 ident dev");
        rd(clg_pkg::PAT_IDENT, 13'h0032, 8'hFF, 1'b1, "R10 ident other");
        idle_cycle("R12 idle after ident");
        drain();

        // R9: reserved single lock bit 2
        prog(clg_pkg::PAT_SET_LK2, 13'h0, 8'h0);
        locked = 1'b1;
        @(negedge clk); pins(clg_pkg::PAT_PROG_CODE, 1'b1); #1;
        chk(prog_en === 1'b0, "R9 reserved blocks prog", {8'h0, prog_en}, 9'h0);
        chk(intcode_rd_ok === 1'b0, "R9 reserved blocks internal read", {8'h0, intcode_rd_ok}, 9'h0);
        @(negedge clk); pins(6'b0, 1'b0);
        prog(clg_pkg::PAT_PROG_SCR, 13'h0004, 8'h00);
        rb(13'h0004, "R9 scramble write ignored");
        rb(13'h0003, "R9 read-back still works");
        drain();

        // R11: erase
        do_erase();
        @(negedge clk); pins(clg_pkg::PAT_PROG_CODE, 1'b1); #1;
        chk(prog_en === 1'b1, "R11 erase restores permit", {8'h0, prog_en}, 9'h1);
        chk(intcode_rd_ok === 1'b1, "R11 erase unlocks", {8'h0, intcode_rd_ok}, 9'h1);
        @(negedge clk); pins(6'b0, 1'b0);
        rb(13'h0003, "R11 erase blanks table");
        drain();

        // R7: lock bit 1
        @(negedge clk); ext_access_in = 1'b0; #1;
        chk(ext_access_eff === 1'b0, "R7 unlocked follows live level", {8'h0, ext_access_eff}, 9'h0);
        @(negedge clk); ext_access_in = 1'b1;
        prog(clg_pkg::PAT_SET_LK1, 13'h0, 8'h0);
        locked = 1'b1;
        @(negedge clk); ext_access_in = 1'b0; #1;
        chk(ext_access_eff === 1'b1, "R7 level frozen", {8'h0, ext_access_eff}, 9'h1);
        chk(intcode_rd_ok === 1'b0, "R7 internal read blocked", {8'h0, intcode_rd_ok}, 9'h0);
        @(negedge clk); pins(clg_pkg::PAT_PROG_CODE, 1'b1); ext_access_in = 1'b1; #1;
        chk(prog_en === 1'b0, "R7 prog blocked", {8'h0, prog_en}, 9'h0);
        @(negedge clk); pins(6'b0, 1'b0);
        prog(clg_pkg::PAT_PROG_SCR, 13'h0006, 8'h00);
        rb(13'h0006, "R7 scramble write ignored, read-back works");
        drain();

        // R8: both lock bits
        prog(clg_pkg::PAT_SET_LK2, 13'h0, 8'h0);
        rd(clg_pkg::PAT_READBACK, 13'h0006, 8'hFF, 1'b0, "R8 read-back blocked");
        rd(clg_pkg::PAT_IDENT, 13'h0030, 8'h89, 1'b1, "R10 ident while locked");
        drain();

        do_erase();
        rb(13'h0006, "R11 read-back after erase");
        drain();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule